// File: doc/BRIEF.md
# Prioritized Interrupt Level Evaluator

This block decides which pending interrupt level the processor should take next, given its current priority level. Three kinds of source compete. A halt pin beats everything. Four hardware levels (0x14 to 0x17) each hold a bank of request bits, one per source. A software summary word marks pending software levels 1 to 15. The winning level is produced combinationally, and 0 means that no interrupt is to be taken.

When the processor acknowledges a hardware level, the block picks the lowest-numbered pending source at that level. In the same cycle it returns that source's vector, built from per-source configuration inputs, and it clears the source's request bit at the next clock edge. Request bits are set by one-cycle pulses on a set input. A bus reset wipes every hardware request. Any device-specific action on acknowledge stays outside the block.

Top module: `irq_level_eval`

## Requirements
- R1: While `halt_pin` is high, `win_level` is 0x1F, whatever the requests and `cur_ipl` are.
- R2: With `halt_pin` low, the hardware levels are examined from 0x17 down to 0x14. A level wins when at least one of its request bits is set and the level is strictly greater than `cur_ipl`.
- R3: As soon as the examination reaches a level that is not above `cur_ipl`, the result is 0. Lower hardware levels and all software levels are ignored in that case. When `cur_ipl` is 15 or more, software levels never win.
- R4: When no hardware level wins and `cur_ipl` is below 15, bit k of `sw_summary` stands for software level k+1. Among the set bits whose level is strictly above `cur_ipl`, the highest level wins. If none is eligible, the result is 0.
- R5: `win_level` is combinational. It reflects the inputs and the current request bits in the same cycle, including a cycle in which an acknowledge is in progress.
- R6: An acknowledge at a hardware level selects the lowest-numbered set request bit at that level. The vector appears in the same cycle, and exactly that bit is cleared at the next rising clock edge.
- R7: The vector of source i at level L is (base OR forced) AND (forced OR 0x1FC), where base and forced are that source's configuration words.
- R8: An acknowledge for a level above 0x17 raises `ack_error`, returns vector 0 and clears nothing. An acknowledge at a level with no pending bit, or at a level below 0x14, returns vector 0 with `ack_error` low.
- R9: A pulse on `hw_set` sets the request bit at the next edge. A set and a clear of the same bit in the same cycle leave the bit set.
- R10: `bus_reset` clears all hardware request bits at the next edge, and set pulses in that cycle are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_reset | input | 1 | Clears all hardware request bits |
| halt_pin | input | 1 | Halt request, highest priority |
| hw_set | input | 4x32 | One-cycle set pulses, [level-0x14][source] |
| sw_summary | input | 15 | Bit k = software level k+1 pending |
| cur_ipl | input | 5 | Current processor priority level |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_level | input | 5 | Level being acknowledged |
| vec_base | input | 4x32x16 | Per-source base vector |
| vec_frc | input | 4x32x16 | Per-source forced-bit pattern |
| win_level | output | 5 | Winning level, 0 for none |
| ack_vector | output | 16 | Vector for the acknowledged source |
| ack_error | output | 1 | Acknowledge for a level above 0x17 |
| hw_req | output | 4x32 | Current hardware request bits |

## Verification
Two events can fall in the same cycle: an acknowledge that clears a source's request bit, and a new set pulse for that same bit. The bench provokes this by pulsing the bit being acknowledged in the acknowledge cycle. It then checks that the bit is still pending afterwards and that a second acknowledge returns the same source again. In that same cycle it also checks that the combinational level decision still reports the level that holds the pending request. A set pulse in the same cycle as a bus reset is provoked as well, and the bench expects it to be dropped.

// File: rtl/irq_eval_pkg.sv
package irq_eval_pkg;

    localparam int LVL_W = 5;
    localparam logic [LVL_W-1:0] HALT_LVL = 5'h1F;
    localparam logic [31:0] VEC_KEEP = 32'h0000_01FC;

    typedef logic [LVL_W-1:0] ipl_t;

    typedef struct packed {
        logic        hit;
        logic [4:0]  src;
    } pick_t;

    function automatic logic [31:0] form_vec(input logic [31:0] base,
                                              input logic [31:0] frc);
        return (base | frc) & (frc | VEC_KEEP);
    endfunction

endpackage

// File: rtl/irq_req_bank.sv
module irq_req_bank #(
    parameter int N_SRC = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_reset,
    input  logic [N_SRC-1:0] set_bits,
    input  logic [N_SRC-1:0] clr_bits,
    output logic [N_SRC-1:0] req,
    output logic             any_req
);

    always_ff @(posedge clk) begin
        if (rst || bus_reset)
            req <= '0;
        else
            req <= (req & ~clr_bits) | set_bits;
    end

    assign any_req = |req;

    // R10
    bus_reset_wipe_chk: assert property (@(posedge clk) disable iff (rst)
        bus_reset |=> (req == '0));

    // R9
    set_lands_chk: assert property (@(posedge clk) disable iff (rst)
        ((set_bits != '0) && !bus_reset) |=> ((req & $past(set_bits)) == $past(set_bits)));

    // R6
    clear_lands_chk: assert property (@(posedge clk) disable iff (rst)
        ((clr_bits & ~set_bits) != '0) |=> ((req & $past(clr_bits & ~set_bits)) == '0));

endmodule

// File: rtl/irq_level_arb.sv
module irq_level_arb
    import irq_eval_pkg::*;
#(
    parameter int N_HW_LVL = 4,
    parameter int HW_TOP   = 'h17,
    parameter int SW_TOP   = 15
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                halt,
    input  logic [N_HW_LVL-1:0] lvl_any,
    input  logic [SW_TOP-1:0]   sw_sum,
    input  ipl_t                cur_ipl,
    output ipl_t                win
);

    localparam int HW_BOT = HW_TOP - N_HW_LVL + 1;

    logic settled;

    always_comb begin
        win     = '0;
        settled = 1'b0;
        if (halt) begin
            win     = HALT_LVL;
            settled = 1'b1;
        end
        for (int k = N_HW_LVL - 1; k >= 0; k--) begin
            if (!settled) begin
                if (HW_BOT + k <= int'(cur_ipl)) begin
                    settled = 1'b1;
                end else if (lvl_any[k]) begin
                    win     = ipl_t'(HW_BOT + k);
                    settled = 1'b1;
                end
            end
        end
        if (!settled && int'(cur_ipl) < SW_TOP) begin
            for (int s = SW_TOP; s >= 1; s--) begin
                if (!settled && s > int'(cur_ipl) && sw_sum[s-1]) begin
                    win     = ipl_t'(s);
                    settled = 1'b1;
                end
            end
        end
    end

    // R1
    halt_wins_chk: assert property (@(posedge clk) disable iff (rst)
        halt |-> (win == HALT_LVL));

    // R2
    above_ipl_chk: assert property (@(posedge clk) disable iff (rst)
        (!halt && win != '0) |-> (win > cur_ipl));

    // R3
    blocked_chk: assert property (@(posedge clk) disable iff (rst)
        (!halt && int'(cur_ipl) >= HW_TOP) |-> (win == '0));

endmodule

// File: rtl/irq_vec_former.sv
module irq_vec_former
    import irq_eval_pkg::*;
#(
    parameter int N_HW_LVL = 4,
    parameter int N_SRC    = 32,
    parameter int VEC_W    = 16,
    parameter int HW_TOP   = 'h17
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic                                   ack_valid,
    input  ipl_t                                   ack_level,
    input  logic [N_HW_LVL-1:0][N_SRC-1:0]         req,
    input  logic [N_HW_LVL-1:0][N_SRC-1:0][VEC_W-1:0] vbase,
    input  logic [N_HW_LVL-1:0][N_SRC-1:0][VEC_W-1:0] vfrc,
    output logic [VEC_W-1:0]                       vec,
    output logic                                   ack_err,
    output logic [N_HW_LVL-1:0][N_SRC-1:0]         clr
);

    localparam int HW_BOT = HW_TOP - N_HW_LVL + 1;

    pick_t [N_HW_LVL-1:0] pick;
    logic  [N_HW_LVL-1:0] lvl_sel;

    for (genvar l = 0; l < N_HW_LVL; l++) begin : g_pick
        always_comb begin
            pick[l] = '0;
            for (int i = N_SRC - 1; i >= 0; i--) begin
                if (req[l][i]) begin
                    pick[l].hit = 1'b1;
                    pick[l].src = 5'(i);
                end
            end
        end
        assign lvl_sel[l] = ack_valid && (int'(ack_level) == HW_BOT + l);
    end

    always_comb begin
        vec     = '0;
        clr     = '0;
        ack_err = ack_valid && (int'(ack_level) > HW_TOP);
        for (int l = 0; l < N_HW_LVL; l++) begin
            if (lvl_sel[l] && pick[l].hit) begin
                clr[l][pick[l].src] = 1'b1;
                vec = VEC_W'(form_vec(32'(vbase[l][pick[l].src]),
                                      32'(vfrc[l][pick[l].src])));
            end
        end
    end

    // R6
    single_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(clr));

    // R8
    err_silent_chk: assert property (@(posedge clk) disable iff (rst)
        ack_err |-> (vec == '0 && clr == '0));

    // R6
    no_ack_no_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !ack_valid |-> (clr == '0));

endmodule

// File: rtl/irq_level_eval.sv
module irq_level_eval
    import irq_eval_pkg::*;
#(
    parameter int N_HW_LVL = 4,
    parameter int N_SRC    = 32,
    parameter int VEC_W    = 16,
    parameter int HW_TOP   = 'h17,
    parameter int SW_TOP   = 15
) (
    input  logic                                       clk,
    input  logic                                       rst,
    input  logic                                       bus_reset,
    input  logic                                       halt_pin,
    input  logic [N_HW_LVL-1:0][N_SRC-1:0]             hw_set,
    input  logic [SW_TOP-1:0]                          sw_summary,
    input  logic [4:0]                                 cur_ipl,
    input  logic                                       ack_valid,
    input  logic [4:0]                                 ack_level,
    input  logic [N_HW_LVL-1:0][N_SRC-1:0][VEC_W-1:0]  vec_base,
    input  logic [N_HW_LVL-1:0][N_SRC-1:0][VEC_W-1:0]  vec_frc,
    output logic [4:0]                                 win_level,
    output logic [VEC_W-1:0]                           ack_vector,
    output logic                                       ack_error,
    output logic [N_HW_LVL-1:0][N_SRC-1:0]             hw_req
);

    logic [N_HW_LVL-1:0][N_SRC-1:0] ack_clr;
    logic [N_HW_LVL-1:0]            lvl_any;

    for (genvar l = 0; l < N_HW_LVL; l++) begin : g_bank
        irq_req_bank #(.N_SRC(N_SRC)) u_bank (
            .clk      (clk),
            .rst      (rst),
            .bus_reset(bus_reset),
            .set_bits (hw_set[l]),
            .clr_bits (ack_clr[l]),
            .req      (hw_req[l]),
            .any_req  (lvl_any[l])
        );
    end

    irq_level_arb #(
        .N_HW_LVL(N_HW_LVL),
        .HW_TOP  (HW_TOP),
        .SW_TOP  (SW_TOP)
    ) u_arb (
        .clk    (clk),
        .rst    (rst),
        .halt   (halt_pin),
        .lvl_any(lvl_any),
        .sw_sum (sw_summary),
        .cur_ipl(cur_ipl),
        .win    (win_level)
    );

    irq_vec_former #(
        .N_HW_LVL(N_HW_LVL),
        .N_SRC   (N_SRC),
        .VEC_W   (VEC_W),
        .HW_TOP  (HW_TOP)
    ) u_vec (
        .clk      (clk),
        .rst      (rst),
        .ack_valid(ack_valid),
        .ack_level(ack_level),
        .req      (hw_req),
        .vbase    (vec_base),
        .vfrc     (vec_frc),
        .vec      (ack_vector),
        .ack_err  (ack_error),
        .clr      (ack_clr)
    );

endmodule

// File: tb/irq_level_eval_bench.sv
module irq_level_eval_bench;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic                     rst, bus_reset, halt_pin, ack_valid, ack_error;
    logic [3:0][31:0]         hw_set, hw_req;
    logic [14:0]              sw_summary;
    logic [4:0]               cur_ipl, ack_level, win_level;
    logic [3:0][31:0][15:0]   vec_base, vec_frc;
    logic [15:0]              ack_vector;

    int nchecks = 0;
    int nerrors = 0;
    bit finished = 0;

    irq_level_eval u_irq_level_eval (
        .clk(clk), .rst(rst), .bus_reset(bus_reset), .halt_pin(halt_pin),
        .hw_set(hw_set), .sw_summary(sw_summary), .cur_ipl(cur_ipl),
        .ack_valid(ack_valid), .ack_level(ack_level), .vec_base(vec_base),
        .vec_frc(vec_frc), .win_level(win_level), .ack_vector(ack_vector),
        .ack_error(ack_error), .hw_req(hw_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
        nchecks++;
        if (act !== expv) begin
            nerrors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    function automatic logic [15:0] base_of(input int l, input int i);
        return 16'hA000 | 16'(l << 7) | 16'(i << 2) | 16'h0001;
    endfunction

    function automatic logic [15:0] frc_of(input int i);
        if (i % 3 == 0) return 16'h2001;
        if (i % 3 == 1) return 16'h0002;
        return 16'h0000;
    endfunction

    function automatic logic [15:0] exp_vec(input int l, input int i);
        return (base_of(l, i) | frc_of(i)) & (frc_of(i) | 16'h01FC);
    endfunction

    function automatic int exp_win(input bit h, input logic [3:0] occ,
                                   input logic [14:0] sw, input int ipl);
        if (h) return 'h1F;
        for (int lv = 'h17; lv >= 'h14; lv--) begin
            if (lv <= ipl) return 0;
            if (occ[lv - 'h14]) return lv;
        end
        if (ipl >= 15) return 0;
        for (int s = 15; s > ipl; s--)
            if (sw[s-1]) return s;
        return 0;
    endfunction

    task automatic do_ack(input int lvl, input logic [15:0] vexp, input bit eexp, input string req);
        ack_valid = 1'b1;
        ack_level = 5'(lvl);
        #5;
        chk(req, 32'(ack_vector), 32'(vexp));
        chk(req, 32'(ack_error), 32'(eexp));
        tick();
        ack_valid = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            nerrors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrors);
            $finish;
        end
    end

    initial begin
        logic [14:0] swp [5];
        swp[0] = 15'h0000; swp[1] = 15'h7FFF; swp[2] = 15'h0421;
        swp[3] = 15'h4000; swp[4] = 15'h0102;
        rst = 1'b1; bus_reset = 1'b0; halt_pin = 1'b0; hw_set = '0;
        sw_summary = '0; cur_ipl = '0; ack_valid = 1'b0; ack_level = '0;
        for (int l = 0; l < 4; l++)
            for (int i = 0; i < 32; i++) begin
                vec_base[l][i] = base_of(l, i);
                vec_frc[l][i]  = frc_of(i);
            end
        tick(); tick();
        rst = 1'b0;
        #3;
        chk("reset R10 hw_req", 32'(hw_req[0] | hw_req[1] | hw_req[2] | hw_req[3]), 0);
        chk("reset R4 win", 32'(win_level), 0);

        // R1 R2 R3 R4 R5: sweep occupancy, ipl, software summary, halt
        for (int occ = 0; occ < 16; occ++) begin
            bus_reset = 1'b1; tick(); bus_reset = 1'b0;
            for (int l = 0; l < 4; l++)
                if (occ[l]) hw_set[l][(occ * 5) % 32] = 1'b1;
            tick();
            hw_set = '0;
            for (int ipl = 0; ipl < 32; ipl++)
                for (int p = 0; p < 5; p++)
                    for (int h = 0; h < 2; h++) begin
                        cur_ipl = 5'(ipl); sw_summary = swp[p]; halt_pin = h[0];
                        #1;
                        chk("R1/R2/R3/R4 win_level", 32'(win_level),
                            32'(exp_win(h[0], 4'(occ), swp[p], ipl)));
                    end
        end
        halt_pin = 1'b0; sw_summary = '0; cur_ipl = '0;

        // R6 R7: drain every level in lowest-first order
        for (int l = 0; l < 4; l++) begin
            bus_reset = 1'b1; tick(); bus_reset = 1'b0;
            hw_set[l] = '1; tick(); hw_set = '0;
            chk("R9 set all", 32'(hw_req[l]), 32'hFFFF_FFFF);
            for (int n = 0; n < 32; n++) begin
                do_ack('h14 + l, exp_vec(l, n), 1'b0, "R6/R7 vector");
                chk("R6 cleared lowest", 32'(hw_req[l]), 32'hFFFF_FFFF << (n + 1));
            end
            do_ack('h14 + l, 16'h0000, 1'b0, "R8 empty level");
        end

        // R8: out-of-range acknowledges leave requests alone
        hw_set[3][5] = 1'b1; hw_set[0][2] = 1'b1; tick(); hw_set = '0;
        do_ack('h18, 16'h0000, 1'b1, "R8 above top");
        chk("R8 no clear above", 32'(hw_req[3]), 32'h0000_0020);
        do_ack('h13, 16'h0000, 1'b0, "R8 below bottom");
        chk("R8 no clear below", 32'(hw_req[0]), 32'h0000_0004);

        // R9 R5: set collides with clear of the same bit
        bus_reset = 1'b1; tick(); bus_reset = 1'b0;
        hw_set[2][4] = 1'b1; hw_set[2][9] = 1'b1; tick(); hw_set = '0;
        hw_set[2][4] = 1'b1;
        ack_valid = 1'b1; ack_level = 5'h16;
        #5;
        chk("R5 win during ack", 32'(win_level), 32'h16);
        chk("R9 collide vector", 32'(ack_vector), 32'(exp_vec(2, 4)));
        tick();
        ack_valid = 1'b0; hw_set = '0;
        chk("R9 collide kept", 32'(hw_req[2]), 32'h0000_0210);
        do_ack('h16, exp_vec(2, 4), 1'b0, "R9 reack same");
        do_ack('h16, exp_vec(2, 9), 1'b0, "R6 next source");
        chk("R6 level empty", 32'(hw_req[2]), 0);

        // R10: bus reset drops simultaneous sets
        hw_set[1][7] = 1'b1; tick();
        hw_set[3][1] = 1'b1; bus_reset = 1'b1; tick();
        hw_set = '0; bus_reset = 1'b0;
        chk("R10 wiped", 32'(hw_req[1] | hw_req[3]), 0);
        chk("R10 win after wipe", 32'(win_level), 0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrors);
        $finish;
    end

endmodule